// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block is the host side of a two-wire read link to an 8-bit serial converter. On a start request it pulls chip-select low and waits out the chip-select setup interval. It then issues exactly eight pulses on a serial clock made by dividing the system clock, and shifts the converter's data line in MSB first, one bit on each rising edge. The converter changes its data after each falling edge, so each rising edge lands in the middle of a stable bit.

The eighth falling edge of every access also starts the converter's next conversion. A read therefore returns the value converted at the end of the previous access. After each access the controller keeps chip-select high for a guard interval that covers the conversion time, and only then allows another access. A start request that arrives while an access or guard is in progress is held and served once the guard ends. The first result after reset is flagged as stale, because no conversion has been triggered before it.

All intervals are counts of system clock cycles. Each is derived from the system clock frequency and a time in nanoseconds, rounded up. The control is one state machine with five states:
- `ST_IDLE`: no access.
- `ST_SETUP`: chip-select low, clock low.
- `ST_HIGH`: clock high.
- `ST_LOW`: clock low between pulses.
- `ST_GUARD`: chip-select high while the conversion runs.

The transitions are:
- `ST_IDLE` to `ST_SETUP` when a request is present.
- `ST_SETUP` to `ST_HIGH` when the setup interval ends.
- `ST_HIGH` to `ST_LOW` when the phase ends.
- `ST_LOW` to `ST_HIGH` when fewer than eight bits have been taken and the phase ends.
- `ST_LOW` to `ST_GUARD` when eight bits have been taken and the phase ends.
- `ST_GUARD` to `ST_IDLE` when the guard interval ends.

Top module: `adc_read_ctrl`

## Requirements
- R1: Reset values: `cs_n`=1, `sclk`=0, `busy`=0, `valid`=0, `result`=0, `stale`=0.
- R2: A `start` seen in `ST_IDLE` drives `cs_n` low and `busy` high in the next cycle. `cs_n` then stays low for exactly SETUP_CYC = ceil(SETUP_NS*CLK_KHZ/1e6) cycles before the first rise of `sclk`.
- R3: Each access has exactly 8 `sclk` pulses. Every high phase and every low phase between pulses lasts exactly HALF_CYC = ceil(HALF_NS*CLK_KHZ/1e6) cycles.
- R4: `miso` is sampled at each rise of `sclk`. The bit taken at the first rise becomes `result[7]` and the bit at the eighth rise becomes `result[0]`.
- R5: `valid` is high for exactly one cycle, in the cycle in which `sclk` rises for the eighth time. `result` takes the new value in that cycle and keeps it until the next `valid`.
- R6: After the eighth fall of `sclk`, `cs_n` stays low for one more HALF_CYC low phase and then rises. It then stays high for at least GUARD_CYC+1 cycles, where GUARD_CYC = ceil(GUARD_NS*CLK_KHZ/1e6).
- R7: `sclk` is low whenever `cs_n` is high.
- R8: A `start` that arrives while `busy` is high (during the transfer or the guard) is held. One such held request produces exactly one further access. In that access `cs_n` falls exactly GUARD_CYC+1 cycles after it rose. Several requests that arrive during one busy interval merge into one.
- R9: `stale` is 1 alongside the first result after reset and 0 alongside every later result.
- R10: `busy` stays high from the cycle after an accepted request until GUARD_CYC cycles after `cs_n` rises, then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one read |
| busy | output | 1 | Access or guard interval in progress |
| valid | output | 1 | One-cycle pulse: new result available |
| result | output | 8 | Last byte read, MSB first on the wire |
| stale | output | 1 | Result predates any triggered conversion |
| cs_n | output | 1 | Converter chip-select, active low |
| sclk | output | 1 | Serial clock to the converter, idles low |
| miso | input | 1 | Serial data from the converter |

## Verification
The bench keeps the default timing parameters with CLK_KHZ = 125000: 404 ns half phases, 1400 ns setup and 17000 ns guard. This gives HALF_CYC = 51, SETUP_CYC = 175 and GUARD_CYC = 2125. The half phase (50.5 cycles exactly) is a non-integer, so the rounding up in the cycle conversion is exercised, while a whole read still stays near 3100 cycles. Exact, unscaled intervals let the bench measure every phase width, the setup interval and the guard gap of a held request to the cycle. A converter model shifts its word out on falling clock edges, which exercises all-zero, all-one and single-bit patterns.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GUARD
    } rd_state_e;

    // Cycles covering a time span, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned khz);
        longint unsigned c;
        c = (ns * khz + 64'd999_999) / 64'd1_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max_of3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/adc_span_timer.sv
module adc_span_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [N-1:0] word_next
);
    logic [N-1:0] word_q;

    assign word_next = {word_q[N-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (clear) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= word_next;
        end
    end
endmodule

// File: rtl/adc_req_hold.sv
module adc_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic take,
    output logic want
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q | req) & ~take;
        end
    end

    assign want = pend_q | req;
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned CLK_KHZ  = 125000,
    parameter int unsigned HALF_NS  = 404,
    parameter int unsigned SETUP_NS = 1400,
    parameter int unsigned GUARD_NS = 17000,
    parameter int unsigned NBITS    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             valid,
    output logic [NBITS-1:0] result,
    output logic             stale,
    output logic             cs_n,
    output logic             sclk,
    input  logic             miso
);
    localparam int unsigned HALF_CYC  = ns_to_cycles(HALF_NS, CLK_KHZ);
    localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_KHZ);
    localparam int unsigned GUARD_CYC = ns_to_cycles(GUARD_NS, CLK_KHZ);
    localparam int unsigned MAX_CYC   = max_of3(HALF_CYC, SETUP_CYC, GUARD_CYC);
    localparam int          CW        = $clog2(MAX_CYC + 1);
    localparam int          BW        = $clog2(NBITS + 1);

    rd_state_e       state_q, state_d;
    logic            tmr_load, tmr_done;
    logic [CW-1:0]   tmr_val;
    logic            take, want, cap;
    logic [BW-1:0]   bit_cnt_q;
    logic [NBITS-1:0] word_next;
    logic            last_bit;
    logic            first_q;

    adc_span_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    adc_bit_shifter #(.N(NBITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take),
        .shift_en  (cap),
        .bit_in    (miso),
        .word_next (word_next)
    );

    adc_req_hold u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (start),
        .take  (take),
        .want  (want)
    );

    assign last_bit = (bit_cnt_q == BW'(NBITS - 1));

    // Next-state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take     = 1'b0;
        cap      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (want) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(SETUP_CYC - 1);
                    take     = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HALF_CYC - 1);
                    cap      = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HALF_CYC - 1);
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (bit_cnt_q == BW'(NBITS)) begin
                        state_d = ST_GUARD;
                        tmr_val = CW'(GUARD_CYC - 1);
                    end else begin
                        state_d = ST_HIGH;
                        tmr_val = CW'(HALF_CYC - 1);
                        cap     = 1'b1;
                    end
                end
            end
            ST_GUARD: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and bit count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n      <= 1'b1;
            sclk      <= 1'b0;
            busy      <= 1'b0;
            valid     <= 1'b0;
            result    <= '0;
            stale     <= 1'b0;
            first_q   <= 1'b1;
            bit_cnt_q <= '0;
        end else begin
            cs_n  <= !(state_d == ST_SETUP || state_d == ST_HIGH || state_d == ST_LOW);
            sclk  <= (state_d == ST_HIGH);
            busy  <= (state_d != ST_IDLE);
            valid <= cap && last_bit;
            if (take) begin
                bit_cnt_q <= '0;
            end else if (cap) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (cap && last_bit) begin
                result  <= word_next;
                stale   <= first_q;
                first_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_read_ctrl_chk.sv
module adc_read_ctrl_chk
    import adc_rd_pkg::*;
#(
    parameter int unsigned CLK_KHZ  = 125000,
    parameter int unsigned HALF_NS  = 404,
    parameter int unsigned SETUP_NS = 1400,
    parameter int unsigned GUARD_NS = 17000
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic valid,
    input logic cs_n,
    input logic sclk
);
    localparam int unsigned HALF_CYC  = ns_to_cycles(HALF_NS, CLK_KHZ);
    localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_KHZ);
    localparam int unsigned GUARD_CYC = ns_to_cycles(GUARD_NS, CLK_KHZ);

    int unsigned hi_run, cs_lo_run, cs_hi_run;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run    <= 0;
            cs_lo_run <= 0;
            cs_hi_run <= 0;
            seen_q    <= 1'b0;
        end else begin
            hi_run    <= sclk ? hi_run + 1 : 0;
            cs_lo_run <= cs_n ? 0 : cs_lo_run + 1;
            cs_hi_run <= cs_n ? cs_hi_run + 1 : 0;
            seen_q    <= seen_q | !cs_n;
        end
    end

    p_setup_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> cs_lo_run >= SETUP_CYC);

    p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_run == HALF_CYC);

    p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    p_guard_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && seen_q) |-> cs_hi_run >= GUARD_CYC + 1);

    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !cs_n));

    p_valid_in_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (busy && !cs_n && sclk));
endmodule

bind adc_read_ctrl adc_read_ctrl_chk #(
    .CLK_KHZ  (CLK_KHZ),
    .HALF_NS  (HALF_NS),
    .SETUP_NS (SETUP_NS),
    .GUARD_NS (GUARD_NS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .valid (valid),
    .cs_n  (cs_n),
    .sclk  (sclk)
);

// File: tb/sim_adc_read_ctrl.sv
`timescale 1ns/1ps
module sim_adc_read_ctrl;
    localparam int HALF  = 51;    // ceil(404*125000/1e6)
    localparam int SETUP = 175;   // ceil(1400*125000/1e6)
    localparam int GUARD = 2125;  // ceil(17000*125000/1e6)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, valid, stale, cs_n, sclk, miso;
    logic [7:0] result;

    int tests = 0;
    int fails = 0;
    logic [7:0] dev_word = 8'h00;
    logic [7:0] dsr = 8'h00;

    always #4 clk = ~clk;

    adc_read_ctrl u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .valid  (valid),
        .result (result),
        .stale  (stale),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .miso   (miso)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model: MSB out when selected, next bit after each falling clock
    logic p_cs = 1'b1, p_sclk = 1'b0;
    assign miso = dsr[7];
    always @(negedge clk) begin
        if (p_cs && !cs_n) dsr <= dev_word;
        else if (p_sclk && !sclk) dsr <= {dsr[6:0], 1'b0};
        p_cs   <= cs_n;
        p_sclk <= sclk;
    end

    // Timing monitor
    int  hi_run = 0, lo_run = 0, cs_lo_run = 0, cs_hi_run = 0, pulses = 0, last_gap = 0;
    bit  seen = 0, idle_bad = 0;
    logic m_cs = 1'b1, m_sclk = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && sclk) idle_bad = 1;
            if (!m_sclk && sclk) begin
                if (pulses == 0) check(cs_lo_run == SETUP, "R2 setup", cs_lo_run, SETUP);
                else             check(lo_run == HALF, "R3 low phase", lo_run, HALF);
                pulses++;
            end
            if (m_sclk && !sclk) check(hi_run == HALF, "R3 high phase", hi_run, HALF);
            if (!m_cs && cs_n) begin
                check(pulses == 8, "R3 pulse count", pulses, 8);
                check(lo_run == HALF, "R6 tail low", lo_run, HALF);
            end
            if (m_cs && !cs_n) begin
                last_gap = cs_hi_run;
                if (seen) check(cs_hi_run >= GUARD + 1, "R6 guard gap", cs_hi_run, GUARD + 1);
                seen = 1;
                pulses = 0;
            end
            hi_run    = sclk ? hi_run + 1 : 0;
            lo_run    = (!sclk && !cs_n) ? lo_run + 1 : 0;
            cs_lo_run = cs_n ? 0 : cs_lo_run + 1;
            cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
            m_cs   = cs_n;
            m_sclk = sclk;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!valid && n < 10000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 10000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        check(cs_n === 1'b1 && sclk === 1'b0, "R1 pins", {cs_n, sclk}, 2);
        check(busy === 1'b0 && valid === 1'b0, "R1 flags", {busy, valid}, 0);
        check(result === 8'h00 && stale === 1'b0, "R1 result", result, 0);
    endtask

    task automatic t_read(input logic [7:0] w, input bit exp_stale);
        int g = 0;
        dev_word = w;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy && !cs_n, "R2 accept", {busy, cs_n}, 2);
        wait_valid();
        check(result == w, "R4 data", result, w);
        check(sclk === 1'b1, "R5 valid on 8th rise", sclk, 1);
        check(stale == exp_stale, "R9 stale", stale, exp_stale);
        @(negedge clk);
        check(!valid, "R5 one cycle", valid, 0);
        while (!cs_n) @(negedge clk);
        while (busy) begin g++; @(negedge clk); end
        check(g == GUARD, "R10 busy after cs rise", g, GUARD);
        check(result == w, "R5 result held", result, w);
    endtask

    task automatic t_held();
        dev_word = 8'h96;
        pulse_start();
        repeat (400) @(negedge clk);
        pulse_start();                    // during transfer
        wait_valid();
        check(result == 8'h96, "R8 first data", result, 8'h96);
        while (!cs_n) @(negedge clk);
        dev_word = 8'h69;
        repeat (100) @(negedge clk);
        pulse_start();                    // during guard, merges
        wait_idle();
        wait_valid();
        check(result == 8'h69, "R8 held data", result, 8'h69);
        check(last_gap == GUARD + 1, "R8 held gap", last_gap, GUARD + 1);
        while (!cs_n) @(negedge clk);
        wait_idle();
        repeat (60) @(negedge clk);
        check(cs_n && !busy, "R8 single extra access", {cs_n, busy}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_read(8'hA5, 1'b1);
        t_read(8'h3C, 1'b0);
        t_read(8'h00, 1'b0);
        t_read(8'hFF, 1'b0);
        t_read(8'h80, 1'b0);
        t_read(8'h01, 1'b0);
        t_held();
        check(!idle_bad, "R7 sclk idle low", idle_bad, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule